// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps the program order of instructions in a small out-of-order core. The decode stage claims an entry at the tail of a circular buffer for each instruction, handing over the destination register tag, and gets back the entry index. Execution units later report results by that index in whatever order they finish. The value is stored in the entry and the entry is marked finished.

Retirement happens only at the head. When the oldest entry has its result, it is presented on the commit port for one cycle, which writes the architectural register file. It is then released. A slow old instruction lets younger ones finish but holds back their retirement, so register state always changes in program order.

A flush input, raised on a branch mispredict, discards every entry at once.

Top module: `ordered_retire_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_full` is 0, `alloc_idx` is 0 and `commit_valid` is 0.
- R2: An allocation is accepted in a cycle with `alloc_req` high, `alloc_full` low and `flush` low. The entry goes at the index shown on `alloc_idx` in that cycle. Successive accepted allocations get consecutive indices, counting up by one.
- R3: With DEPTH entries held and no retirement in the cycle, `alloc_full` is 1 and a request is refused: no entry is taken and `alloc_idx` does not move.
- R4: A completion (`cmp_valid` with `cmp_idx`, `cmp_data`) to a held entry stores `cmp_data` and marks the entry finished. That value is later presented on `commit_data`.
- R5: `commit_valid` is high in a cycle only when the head entry is held and finished. `commit_reg` and `commit_data` then carry that entry's tag and stored value. At most one entry retires per cycle.
- R6: Entries retire strictly in allocation order. A finished younger entry does not retire while an older one is unfinished; once the older one finishes, the waiting entries retire on consecutive cycles.
- R7: A completion whose index names an entry that is not held is ignored. An entry allocated there later still waits for its own completion.
- R8: `flush` takes effect in its cycle: no retirement, no allocation and no completion happen. The next cycle the buffer is empty and `alloc_idx` is 0.
- R9: In a cycle where the head retires while the buffer is full, `alloc_full` is 0 and a request is accepted into the slot being freed.
- R10: Indices wrap: after index DEPTH-1 the next allocation uses index 0, and the head follows the same wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every entry (mispredict) |
| alloc_req | input | 1 | Request a new entry at the tail |
| alloc_dst | input | TAG_W | Destination register tag of the new instruction |
| alloc_full | output | 1 | Request would be refused this cycle |
| alloc_idx | output | $clog2(DEPTH) | Index the next accepted entry receives |
| cmp_valid | input | 1 | A result is reported this cycle |
| cmp_idx | input | $clog2(DEPTH) | Entry index of the reported result |
| cmp_data | input | DATA_W | Reported result value |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_reg | output | TAG_W | Destination register of the retiring entry |
| commit_data | output | DATA_W | Value of the retiring entry |

## Verification
The bench builds the buffer with DEPTH 4, 3-bit tags and 8-bit values. With only four entries, every one of the 24 completion orders of a full buffer can be enumerated, each followed by its in-order drain. Full, wrap and retire-while-full states come up within a few cycles, so a long pseudo-random mix of allocations, completions (to held and to free slots) and flushes passes through them many times. Every cycle is compared against an arithmetic model of head, occupancy and per-slot state.

// File: rtl/orb_pkg.sv
package orb_pkg;

  // What happens to one slot in a cycle, highest priority first in the bank.
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_FILL = 2'd1,
    EV_FREE = 2'd2,
    EV_DONE = 2'd3
  } slot_ev_e;

  // Occupancy from two wrapped pointers of pw bits.
  function automatic int unsigned ptr_span(input int unsigned head,
                                           input int unsigned tail,
                                           input int unsigned pw);
    return (tail - head) & ((32'd1 << pw) - 32'd1);
  endfunction

  // Full when the index bits match and the wrap bits differ.
  function automatic bit ptr_is_full(input int unsigned head,
                                     input int unsigned tail,
                                     input int unsigned idx_w);
    return (head ^ tail) == (32'd1 << idx_w);
  endfunction

endpackage

// File: rtl/orb_ptr_ctrl.sv
module orb_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_fire,
  input  logic             commit_fire,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [PTR_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [PTR_W-1:0] head_q;
  logic [PTR_W-1:0] tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (alloc_fire)  tail_q <= tail_q + PTR_W'(1);
      if (commit_fire) head_q <= head_q + PTR_W'(1);
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign count    = PTR_W'(orb_pkg::ptr_span(32'(head_q), 32'(tail_q), PTR_W));
  assign full     = orb_pkg::ptr_is_full(32'(head_q), 32'(tail_q), IDX_W);
  assign empty    = (head_q == tail_q);

endmodule

// File: rtl/orb_entry_bank.sv
module orb_entry_bank #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_fire,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [TAG_W-1:0]  alloc_dst,
  input  logic              commit_fire,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_data,
  output logic              cmp_hit,
  output logic              head_valid,
  output logic              head_done,
  output logic [TAG_W-1:0]  head_dst,
  output logic [DATA_W-1:0] head_data
);

  logic [DEPTH-1:0]  valid_vec;
  logic [DEPTH-1:0]  done_vec;
  logic [TAG_W-1:0]  tag_arr  [DEPTH];
  logic [DATA_W-1:0] data_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              v_q;
    logic              d_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] x_q;
    orb_pkg::slot_ev_e ev;

    // Fill beats free (retire and refill in one cycle); free beats a late result.
    always_comb begin
      ev = orb_pkg::EV_NONE;
      if (alloc_fire && alloc_idx == IDX_W'(i))
        ev = orb_pkg::EV_FILL;
      else if (commit_fire && head_idx == IDX_W'(i))
        ev = orb_pkg::EV_FREE;
      else if (cmp_valid && cmp_idx == IDX_W'(i) && v_q)
        ev = orb_pkg::EV_DONE;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
        x_q <= '0;
      end else if (flush) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else begin
        case (ev)
          orb_pkg::EV_FILL: begin
            v_q <= 1'b1;
            d_q <= 1'b0;
            t_q <= alloc_dst;
          end
          orb_pkg::EV_FREE: begin
            v_q <= 1'b0;
            d_q <= 1'b0;
          end
          orb_pkg::EV_DONE: begin
            d_q <= 1'b1;
            x_q <= cmp_data;
          end
          default: ;
        endcase
      end
    end

    assign valid_vec[i] = v_q;
    assign done_vec[i]  = d_q;
    assign tag_arr[i]   = t_q;
    assign data_arr[i]  = x_q;
  end

  assign cmp_hit    = cmp_valid && valid_vec[cmp_idx];
  assign head_valid = valid_vec[head_idx];
  assign head_done  = done_vec[head_idx];
  assign head_dst   = tag_arr[head_idx];
  assign head_data  = data_arr[head_idx];

endmodule

// File: rtl/ordered_retire_buf.sv
module ordered_retire_buf #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_req,
  input  logic [TAG_W-1:0]  alloc_dst,
  output logic              alloc_full,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_data,
  output logic              commit_valid,
  output logic [TAG_W-1:0]  commit_reg,
  output logic [DATA_W-1:0] commit_data
);

  // Named internal events, observed by the bound checker.
  logic             alloc_fire;
  logic             commit_fire;
  logic             cmp_hit;
  logic             head_valid;
  logic             head_done;
  logic             full;
  logic             empty;
  logic [PTR_W-1:0] count;
  logic [IDX_W-1:0] head_idx;
  logic [IDX_W-1:0] tail_idx;
  logic [TAG_W-1:0] head_dst;
  logic [DATA_W-1:0] head_data;

  assign commit_fire = head_valid && head_done && !flush;
  assign alloc_full  = full && !commit_fire;
  assign alloc_fire  = alloc_req && !alloc_full && !flush;

  orb_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .alloc_fire  (alloc_fire),
    .commit_fire (commit_fire),
    .head_idx    (head_idx),
    .tail_idx    (tail_idx),
    .count       (count),
    .full        (full),
    .empty       (empty)
  );

  orb_entry_bank #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) bank_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .alloc_fire  (alloc_fire),
    .alloc_idx   (tail_idx),
    .alloc_dst   (alloc_dst),
    .commit_fire (commit_fire),
    .head_idx    (head_idx),
    .cmp_valid   (cmp_valid),
    .cmp_idx     (cmp_idx),
    .cmp_data    (cmp_data),
    .cmp_hit     (cmp_hit),
    .head_valid  (head_valid),
    .head_done   (head_done),
    .head_dst    (head_dst),
    .head_data   (head_data)
  );

  assign alloc_idx    = tail_idx;
  assign commit_valid = commit_fire;
  assign commit_reg   = head_dst;
  assign commit_data  = head_data;

endmodule

// File: rtl/orb_checker.sv
module orb_checker #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          alloc_fire,
  input logic          commit_fire,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] count
);

  // R3
  refuse_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !commit_fire) |-> !alloc_fire);

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !commit_fire));

  // R2
  occupancy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (count == CW'($past(count) + CW'($past(alloc_fire)) - CW'($past(commit_fire)))));

  // R5
  retire_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> !empty);

  // R3
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R10
  full_matches_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (count == CW'(DEPTH)));

endmodule

bind ordered_retire_buf orb_checker #(.DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .alloc_fire  (alloc_fire),
  .commit_fire (commit_fire),
  .full        (full),
  .empty       (empty),
  .count       (count)
);

// File: tb/ordered_retire_buf_tb_top.sv
module ordered_retire_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int TW = 3;
  localparam int DW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic alloc_req = 1'b0;
  logic [TW-1:0] alloc_dst = '0;
  logic alloc_full;
  logic [IW-1:0] alloc_idx;
  logic cmp_valid = 1'b0;
  logic [IW-1:0] cmp_idx = '0;
  logic [DW-1:0] cmp_data = '0;
  logic commit_valid;
  logic [TW-1:0] commit_reg;
  logic [DW-1:0] commit_data;

  ordered_retire_buf #(.DEPTH(D), .TAG_W(TW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_req(alloc_req), .alloc_dst(alloc_dst),
    .alloc_full(alloc_full), .alloc_idx(alloc_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_data(cmp_data),
    .commit_valid(commit_valid), .commit_reg(commit_reg), .commit_data(commit_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int n_commit = 0;
  bit finished = 1'b0;

  // Arithmetic model of the buffer, built from the requirements.
  bit m_v [D];
  bit m_d [D];
  int m_t [D];
  int m_x [D];
  int m_head = 0;
  int m_cnt = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < D; k++) begin
      m_v[k] = 1'b0;
      m_d[k] = 1'b0;
      m_t[k] = 0;
      m_x[k] = 0;
    end
    m_head = 0;
    m_cnt = 0;
  endtask

  // One cycle: drive after the falling edge, compare, then advance the model.
  task automatic step(input bit req, input int dst, input bit cv, input int ci,
                      input int cd, input bit fl);
    bit exp_cm;
    bit exp_full;
    int tail;
    @(negedge clk);
    alloc_req = req;
    alloc_dst = TW'(dst);
    cmp_valid = cv;
    cmp_idx   = IW'(ci);
    cmp_data  = DW'(cd);
    flush     = fl;
    #1;
    exp_cm   = !fl && m_cnt > 0 && m_v[m_head] && m_d[m_head];
    exp_full = (m_cnt == D) && !exp_cm;
    tail     = (m_head + m_cnt) % D;
    chk("R3", "alloc_full", int'(alloc_full), int'(exp_full));
    chk("R2", "alloc_idx", int'(alloc_idx), tail);
    chk("R6", "commit_valid", int'(commit_valid), int'(exp_cm));
    if (exp_cm) begin
      chk("R5", "commit_reg", int'(commit_reg), m_t[m_head]);
      chk("R4", "commit_data", int'(commit_data), m_x[m_head]);
    end
    if (commit_valid) n_commit++;
    if (fl) begin
      model_clear();
    end else begin
      if (cv && m_v[ci % D]) begin
        m_d[ci % D] = 1'b1;
        m_x[ci % D] = cd % 256;
      end
      if (exp_cm) begin
        m_v[m_head] = 1'b0;
        m_d[m_head] = 1'b0;
        m_head = (m_head + 1) % D;
        m_cnt--;
      end
      if (req && !exp_full) begin
        m_v[tail] = 1'b1;
        m_d[tail] = 1'b0;
        m_t[tail] = dst % 8;
        m_cnt++;
      end
    end
  endtask

  task automatic idle();
    step(1'b0, 0, 1'b0, 0, 0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    bit [15:0] lfsr;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "alloc_full", int'(alloc_full), 0);
    chk("R1", "alloc_idx", int'(alloc_idx), 0);
    chk("R1", "commit_valid", int'(commit_valid), 0);

    // R2 / R3: fill the buffer, then one refused request
    for (int k = 0; k < D; k++) step(1'b1, 5 + k, 1'b0, 0, 0, 1'b0);
    step(1'b1, 1, 1'b0, 0, 0, 1'b0);
    chk("R3", "refused alloc_full", int'(alloc_full), 1);
    idle();
    chk("R3", "idx after refusal", int'(alloc_idx), 0);

    // R6: younger entries finish first, head blocks
    step(1'b0, 0, 1'b1, 2, 8'h22, 1'b0);
    step(1'b0, 0, 1'b1, 3, 8'h33, 1'b0);
    idle();
    chk("R6", "blocked by head", int'(commit_valid), 0);
    step(1'b0, 0, 1'b1, 0, 8'h10, 1'b0);
    // R9: head retires while full, allocation into the freed slot
    step(1'b1, 6, 1'b0, 0, 0, 1'b0);
    chk("R9", "alloc_full while retiring", int'(alloc_full), 0);
    chk("R9", "alloc into freed slot", int'(alloc_idx), 0);
    chk("R4", "head value", int'(commit_data), 8'h10);
    step(1'b0, 0, 1'b1, 1, 8'h11, 1'b0);
    c0 = n_commit;
    idle(); idle(); idle();
    chk("R6", "in-order drain count", n_commit - c0, 3);
    // R10: tail wrapped from 3 to 0, now sits at 1
    chk("R10", "wrapped tail", int'(alloc_idx), 1);
    idle();
    chk("R6", "undone new head holds", int'(commit_valid), 0);

    // R8: flush with a completion and a request in the same cycle
    step(1'b1, 2, 1'b1, 0, 8'h44, 1'b1);
    idle();
    chk("R8", "no retire after flush", int'(commit_valid), 0);
    chk("R8", "idx after flush", int'(alloc_idx), 0);
    chk("R8", "not full after flush", int'(alloc_full), 0);

    // R7: completion to a free slot is ignored
    step(1'b0, 0, 1'b1, 1, 8'h55, 1'b0);
    step(1'b1, 3, 1'b0, 0, 0, 1'b0);
    step(1'b1, 4, 1'b0, 0, 0, 1'b0);
    step(1'b0, 0, 1'b1, 0, 8'h66, 1'b0);
    idle();
    idle();
    chk("R7", "stale completion ignored", int'(commit_valid), 0);
    step(1'b0, 0, 1'b0, 0, 0, 1'b1);

    // R6 sweep: every completion order of a full buffer
    for (int a = 0; a < D; a++)
      for (int b = 0; b < D; b++)
        for (int c = 0; c < D; c++)
          for (int e = 0; e < D; e++) begin
            if (a != b && a != c && a != e && b != c && b != e && c != e) begin
              int ord [4];
              ord[0] = a; ord[1] = b; ord[2] = c; ord[3] = e;
              step(1'b0, 0, 1'b0, 0, 0, 1'b1);
              c0 = n_commit;
              for (int k = 0; k < D; k++) step(1'b1, k + a, 1'b0, 0, 0, 1'b0);
              for (int k = 0; k < D; k++)
                step(1'b0, 0, 1'b1, ord[k], 16 * a + 4 * b + k, 1'b0);
              for (int k = 0; k < D; k++) idle();
              chk("R6", "commits per order", n_commit - c0, D);
            end
          end

    // Pseudo-random mix, R10 wrap and R9 overlap reached repeatedly
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], int'(lfsr[4:2]), lfsr[5] | lfsr[6], int'(lfsr[8:7]),
           int'(lfsr[15:8]), lfsr[15:10] == 6'd0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule